// File: doc/BRIEF.md
# Latched Switch-Matrix Channel Controller with Readback

This block is the digital control path of an analog switch matrix with two banks of switches, bank A and bank B, each of `NUM_IN/2` channels. A host writes a channel address and an enable bit over a shared bidirectional bus. The bus is modelled as separate in, out and output-enable signals. The block holds those bits in a capture register and decodes them into one-hot switch-enable outputs for each bank.

While the write strobe is low and the bus direction is set to "write", the capture register follows the bus on every clock. Raising the strobe freezes it. The same bus pins can be turned around to read the held address and enable back. A mode input selects one of two decodes. In single-ended mode exactly one switch of the whole matrix is on. In differential mode the same channel is on in both banks.

The switch outputs are registered, and a changed selection always passes through one all-off cycle. An asynchronous active-low reset opens every switch. The illegal combination of read direction with the strobe low is refused and flagged. One parameter selects an 8-input or a 4-input matrix.

Top module: `swmux_ctrl`

## Requirements
- R1: `rstN` low clears, asynchronously and with priority over all other inputs, the held address and enable, all switch outputs and the error flag, and it keeps `busOe` low.
- R2: With `rstN`=1, `wrN`=0 and `dirRead`=0, the held value is loaded from `busIn` at every rising clock edge, so the last bus value before `wrN` rises is kept. `busIn` bit `ADDR_W` is the enable and bits `ADDR_W-1:0` are the address.
- R3: While `wrN`=1 the held address and enable do not change, whatever `busIn` carries.
- R4: When the held enable bit is 0, every switch output is 0 one clock later, whatever the held address.
- R5: In single-ended mode (`diffMode`=0), address MSB 1 selects bank B and 0 selects bank A. The remaining address bits give the channel index c, which drives bit c of that bank's output. At most one output bit of the whole matrix is 1.
- R6: In differential mode (`diffMode`=1), the address MSB is ignored, and bit c is set in both `swA` and `swB`.
- R7: With `rstN`=1, `wrN`=1 and `dirRead`=1, `busOe` is 1 and `busOut` equals the held value, with the enable at bit `ADDR_W` and the address below it.
- R8: With `wrN`=1 and `dirRead`=0, `busOe` is 0 and the held state is kept.
- R9: With `dirRead`=1 and `wrN`=0, the bus is not driven and the held value is unchanged. `protoErr` becomes 1 at the next clock edge and stays 1 until reset.
- R10: The switch outputs are registered. At each edge they keep their value if it equals the decoded target. Otherwise, if they are nonzero, they go to all-zero for one cycle; if they are zero, they load the target. A changed nonzero selection therefore appears two edges after it is decoded, with one all-off cycle in between.
- R11: With `NUM_IN`=4 the address has two bits: bit 1 selects the bank and bit 0 the channel, and each bank output is two bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrN | input | 1 | Write strobe, active low |
| dirRead | input | 1 | Bus direction: 1 = read back, 0 = write |
| diffMode | input | 1 | 1 = differential (paired banks), 0 = single-ended |
| busIn | input | ADDR_W+1 | Bus value seen at the pins: {enable, address} |
| busOut | output | ADDR_W+1 | Readback value: {enable, address} |
| busOe | output | 1 | Drive enable for the shared pins |
| swA | output | NUM_IN/2 | One-hot switch enables, bank A |
| swB | output | NUM_IN/2 | One-hot switch enables, bank B |
| protoErr | output | 1 | Sticky flag for a read direction with the strobe low |

## Verification
The readback signals `busOe` and `busOut` are combinational from the control inputs and the held value. They are checked one time step after the bench changes the inputs. A written value is held from the first rising edge. The switch outputs follow at the next edge when they were off, or one edge later after the all-off cycle when they were on. The bench drives inputs on the falling edge and steps a cycle model of the held value, outputs and flag with each rising edge. It compares the outputs at the next falling edge, so every comparison falls exactly in the cycle its result is due. Asynchronous reset is checked one step after `rstN` falls, between edges.

// File: rtl/swmux_pkg.sv
package swmux_pkg;

  typedef struct packed {
    logic capture;
    logic drive;
    logic illegal;
  } ctrlStrobe_t;

endpackage

// File: rtl/swmux_control.sv
module swmux_control
  import swmux_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrN,
  input  logic        dirRead,
  output ctrlStrobe_t strobe,
  output logic        protoErr
);

  // Decode the bus handshake into one strobe per action.
  always_comb begin
    strobe.capture = rstN && !wrN && !dirRead;
    strobe.drive   = rstN &&  wrN &&  dirRead;
    strobe.illegal = rstN && !wrN &&  dirRead;
  end

  // Sticky error: set by an illegal handshake, cleared only by reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               protoErr <= 1'b0;
    else if (strobe.illegal) protoErr <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr); // R9
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (dirRead && !wrN) |=> protoErr); // R9

endmodule

// File: rtl/swmux_datapath.sv
module swmux_datapath
  import swmux_pkg::*;
#(
  parameter int NUM_IN = 8,
  localparam int BANK_CH = NUM_IN / 2,
  localparam int ADDR_W  = $clog2(NUM_IN),
  localparam int CH_W    = ADDR_W - 1,
  localparam int BUS_W   = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic               diffMode,
  input  logic [BUS_W-1:0]   busIn,
  output logic [BUS_W-1:0]   busOut,
  output logic               busOe,
  output logic [BANK_CH-1:0] swA,
  output logic [BANK_CH-1:0] swB
);

  localparam int ALL_W = 2 * BANK_CH;

  logic [ADDR_W-1:0]  latAddr;
  logic               latEn;
  logic [BANK_CH-1:0] tgtA;
  logic [BANK_CH-1:0] tgtB;
  logic [ALL_W-1:0]   tgtAll;
  logic [ALL_W-1:0]   outAll;
  logic [ALL_W-1:0]   outNext;
  logic               bankSel;

  // Capture register: follows the bus while the capture strobe is active.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr <= '0;
      latEn   <= 1'b0;
    end else if (strobe.capture) begin
      latAddr <= busIn[ADDR_W-1:0];
      latEn   <= busIn[ADDR_W];
    end
  end

  assign bankSel = latAddr[ADDR_W-1];

  // Channel decode, one slice per channel of each bank.
  for (genvar c = 0; c < BANK_CH; c++) begin : g_dec
    logic chHit;
    assign chHit   = latEn && (latAddr[CH_W-1:0] == CH_W'(c));
    assign tgtA[c] = chHit && (diffMode || !bankSel);
    assign tgtB[c] = chHit && (diffMode ||  bankSel);
  end

  assign tgtAll = {tgtB, tgtA};

  // Break-before-make: a changed nonzero set passes through all-off.
  always_comb begin
    if (outAll == tgtAll)    outNext = outAll;
    else if (outAll != '0)   outNext = '0;
    else                     outNext = tgtAll;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outAll <= '0;
    else       outAll <= outNext;
  end

  assign swA = outAll[BANK_CH-1:0];
  assign swB = outAll[ALL_W-1:BANK_CH];

  // Readback path onto the shared pins.
  assign busOe  = strobe.drive;
  assign busOut = strobe.drive ? {latEn, latAddr} : '0;

  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable({latEn, latAddr})); // R3
  AST_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !latEn |=> (outAll == '0)); // R4
  AST_SE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    !diffMode |=> ($countones(outAll) <= 1)); // R5
  AST_DIFF_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    diffMode |=> (swA == swB)); // R6
  AST_BBM_GAP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(outAll) != '0 && outAll != '0) |-> (outAll == $past(outAll))); // R10

endmodule

// File: rtl/swmux_ctrl.sv
module swmux_ctrl
  import swmux_pkg::*;
#(
  parameter int NUM_IN = 8,
  localparam int BANK_CH = NUM_IN / 2,
  localparam int ADDR_W  = $clog2(NUM_IN),
  localparam int BUS_W   = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrN,
  input  logic               dirRead,
  input  logic               diffMode,
  input  logic [BUS_W-1:0]   busIn,
  output logic [BUS_W-1:0]   busOut,
  output logic               busOe,
  output logic [BANK_CH-1:0] swA,
  output logic [BANK_CH-1:0] swB,
  output logic               protoErr
);

  ctrlStrobe_t strobe;

  swmux_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .wrN      (wrN),
    .dirRead  (dirRead),
    .strobe   (strobe),
    .protoErr (protoErr)
  );

  swmux_datapath #(.NUM_IN(NUM_IN)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .diffMode (diffMode),
    .busIn    (busIn),
    .busOut   (busOut),
    .busOe    (busOe),
    .swA      (swA),
    .swB      (swB)
  );

  AST_NO_BUS_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> !busOe); // R9

endmodule

// File: tb/swmux_ctrl_bench.sv
module swmux_ctrl_bench;

  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rstN, wrN, dirRead, diffMode;
  logic [3:0] busIn, busOut;
  logic       busOe, protoErr;
  logic [3:0] swA, swB;
  logic [2:0] busIn4, busOut4;
  logic       busOe4, protoErr4;
  logic [1:0] swA4, swB4;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  logic [3:0] mLatch;
  logic [7:0] mOut;
  logic       mErr;

  always #(CLK_P/2) clk = ~clk;

  swmux_ctrl #(.NUM_IN(8)) u_swmux_ctrl (
    .clk(clk), .rstN(rstN), .wrN(wrN), .dirRead(dirRead), .diffMode(diffMode),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .swA(swA), .swB(swB),
    .protoErr(protoErr));

  swmux_ctrl #(.NUM_IN(4)) u_swmux_ctrl_n4 (
    .clk(clk), .rstN(rstN), .wrN(wrN), .dirRead(dirRead), .diffMode(diffMode),
    .busIn(busIn4), .busOut(busOut4), .busOe(busOe4), .swA(swA4), .swB(swB4),
    .protoErr(protoErr4));

  function automatic logic [7:0] target(logic [3:0] v, logic mode);
    logic [3:0] one;
    one = 4'b0001 << v[1:0];
    if (!v[3])     return 8'h00;
    if (mode)      return {one, one};
    if (v[2])      return {one, 4'h0};
    return {4'h0, one};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    mLatch = '0; mOut = '0; mErr = 1'b0;
  endtask

  // One clock: advance model with the inputs seen at the edge, compare after.
  task automatic tick(string tag);
    logic [3:0] nLatch;
    logic [7:0] nOut, tgt;
    logic       nErr;
    if (!rstN) begin
      nLatch = '0; nOut = '0; nErr = 1'b0;
    end else begin
      nLatch = (!wrN && !dirRead) ? busIn : mLatch;
      nErr   = mErr | (!wrN && dirRead);
      tgt    = target(mLatch, diffMode);
      if (mOut == tgt)       nOut = mOut;
      else if (mOut != '0)   nOut = '0;
      else                   nOut = tgt;
    end
    @(posedge clk);
    @(negedge clk);
    mLatch = nLatch; mOut = nOut; mErr = nErr;
    chk({tag, " R10 outputs"}, {24'h0, swB, swA}, {24'h0, mOut});
    chk("R9 flag", {31'h0, protoErr}, {31'h0, mErr});
  endtask

  task automatic setBus(logic w, logic d, logic [3:0] v);
    wrN = w; dirRead = d; busIn = v;
  endtask

  task automatic readBack(string tag, logic [3:0] exp);
    setBus(1'b1, 1'b1, busIn);
    #1;
    chk({tag, " oe"}, {31'h0, busOe}, 32'h1);
    chk({tag, " value"}, {28'h0, busOut}, {28'h0, exp});
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; diffMode = 1'b0; busIn4 = 3'b110;
    setBus(1'b1, 1'b0, 4'h0);
    modelClear();
    tick("R1"); tick("R1");
    rstN = 1'b1;
    #1;
    chk("R1 reset outputs", {24'h0, swB, swA}, 32'h0);
    chk("R1 reset flag", {31'h0, protoErr}, 32'h0);
    chk("R1 reset oe", {31'h0, busOe}, 32'h0);

    // R5 single-ended: addr 101 -> bank B, channel 1
    setBus(1'b0, 1'b0, 4'hD); tick("R2");
    setBus(1'b1, 1'b0, 4'h0); tick("R5");
    chk("R5 bank B ch1", {24'h0, swB, swA}, 32'h20);
    readBack("R7", 4'hD);
    setBus(1'b1, 1'b0, 4'h0);

    // R10 change of selection: addr 001 -> bank A ch1 via all-off gap
    setBus(1'b0, 1'b0, 4'h9); tick("R2");
    setBus(1'b1, 1'b0, 4'h0); tick("R10");
    chk("R10 gap", {24'h0, swB, swA}, 32'h0);
    tick("R10");
    chk("R5 bank A ch1", {24'h0, swB, swA}, 32'h02);

    // R6 differential
    diffMode = 1'b1; tick("R6"); tick("R6");
    chk("R6 pair", {24'h0, swB, swA}, 32'h22);
    setBus(1'b0, 1'b0, 4'hD); tick("R6");
    setBus(1'b1, 1'b0, 4'h0); tick("R6");
    chk("R6 msb ignored", {24'h0, swB, swA}, 32'h22);

    // R2 transparency over several cycles
    setBus(1'b0, 1'b0, 4'hA); tick("R2");
    busIn = 4'hB; tick("R2");
    busIn = 4'hF; tick("R2");
    setBus(1'b1, 1'b0, 4'h0); tick("R2");
    readBack("R2 last value kept", 4'hF);

    // R4 enable low
    setBus(1'b0, 1'b0, 4'h7); tick("R4");
    setBus(1'b1, 1'b0, 4'h0); tick("R4"); tick("R4"); tick("R4");
    chk("R4 all off", {24'h0, swB, swA}, 32'h0);

    // R3/R8 hold while strobe high
    setBus(1'b1, 1'b0, 4'hE); #1;
    chk("R8 no drive", {31'h0, busOe}, 32'h0);
    tick("R3"); tick("R3");
    readBack("R3 held", 4'h7);

    // R9 illegal handshake
    setBus(1'b0, 1'b1, 4'hE); #1;
    chk("R9 no drive", {31'h0, busOe}, 32'h0);
    tick("R9");
    chk("R9 flag set", {31'h0, protoErr}, 32'h1);
    setBus(1'b1, 1'b0, 4'h0); tick("R9"); tick("R9");
    chk("R9 flag sticky", {31'h0, protoErr}, 32'h1);
    readBack("R9 latch unchanged", 4'h7);

    // R1 asynchronous reset between edges
    setBus(1'b0, 1'b0, 4'hC); tick("R1");
    setBus(1'b1, 1'b1, 4'h0); tick("R1"); tick("R1");
    #2;
    rstN = 1'b0; modelClear(); #1;
    chk("R1 async outputs", {24'h0, swB, swA}, 32'h0);
    chk("R1 async flag", {31'h0, protoErr}, 32'h0);
    chk("R1 priority oe", {31'h0, busOe}, 32'h0);
    tick("R1");
    rstN = 1'b1; setBus(1'b1, 1'b0, 4'h0); tick("R1");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 40) begin
        setBus(1'b0, 1'b0, 4'($urandom));
      end else if (r < 60) begin
        readBack("R7 random", mLatch);
      end else if (r < 63) begin
        setBus(1'b0, 1'b1, 4'($urandom));
        #1; chk("R9 random no drive", {31'h0, busOe}, 32'h0);
      end else if (r < 65) begin
        rstN = 1'b0; modelClear(); #1;
        chk("R1 random reset", {24'h0, swB, swA}, 32'h0);
        tick("R1");
        rstN = 1'b1;
        setBus(1'b1, 1'b0, 4'h0);
      end else begin
        setBus(1'b1, 1'b0, 4'($urandom));
        diffMode = 1'($urandom);
        #1; chk("R8 random no drive", {31'h0, busOe}, 32'h0);
      end
      tick("R5 R6");
    end

    // R11 four-input variant
    diffMode = 1'b0; busIn4 = 3'b110;
    setBus(1'b0, 1'b0, 4'h0); tick("R11");
    setBus(1'b1, 1'b0, 4'h0); tick("R11"); tick("R11"); tick("R11");
    chk("R11 bank B ch0", {28'h0, swB4, swA4}, 32'h4);
    busIn4 = 3'b101;
    setBus(1'b0, 1'b0, 4'h0); tick("R11");
    setBus(1'b1, 1'b0, 4'h0); tick("R11"); tick("R11"); tick("R11");
    chk("R11 bank A ch1", {28'h0, swB4, swA4}, 32'h2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule